// File: doc/BRIEF.md
# Multi-Channel PWM Match Timer

This block is a prescaled up-counter that is compared against seven match values. Six pulse-width outputs are derived from those compares. Match value 0 normally sets the period: its reset-on-match control returns the counter to zero. Match values 1 to 6 place the output edges. Output 1 always runs single-edge. Outputs 2 to 6 can each be switched to dual-edge, where the neighbouring lower match value places the rising edge.

A simple write port loads the configuration. Match values are written to shadow copies. A shadow copy is moved into the active compare register only when two things hold: its latch bit is armed, and the counter is reset by a match. A new duty cycle therefore never cuts a period in half. The counter can be enabled, held in reset, or stopped by a match. A sticky per-match flag vector, cleared by writing ones, drives one interrupt line.

Top module: `pwm_match_timer`

## Requirements
- R1: After synchronous reset the count, all outputs, all flags, the interrupt and the run status are 0. All active match values are 0.
- R2: The prescale field holds divisor minus one (address 1). While running, the count advances exactly once every prescale+1 clock cycles.
- R3: The match control word is at address 2. Match m uses bits 3m (interrupt), 3m+1 (reset) and 3m+2 (stop). On a count step where the count equals an active match value with its reset bit set, the count goes to 0 instead of incrementing. With match 0 at value P, the period is P+1 steps.
- R4: A write to address 8+m changes only the shadow of match m. Writing ones to address 4 arms latch bits. An armed shadow moves to the active register on the next match-triggered counter reset, and then its latch bit clears. Unarmed shadows never take effect.
- R5: In single-edge mode, output n (pwm_o bit n-1) rises when match 0 hits and falls when match n hits. With match 0 as period, it is high for counts 0 to MRn.
- R6: Output control is at address 3. For n = 2 to 6, bit 7+n selects dual-edge mode for output n. Output n is then set by a hit of match n-1 and cleared by a hit of match n, so it is high for counts above MR(n-1) up to MRn. A clear wins over a set in the same step.
- R7: Output n is driven only when its enable (address 3, bit n-1) and the PWM enable (control bit 2) are both 1. Otherwise it reads 0.
- R8: A hit on match m whose interrupt bit is set raises flag m. Writing address 5 clears the flags whose data bits are 1 and leaves the others. irq_o is the OR of all flags.
- R9: A hit on a match whose stop bit is set clears the run bit, and the count then holds its value.
- R10: The control word is at address 0: bit 0 is run, bit 1 is counter reset, bit 2 is PWM enable. While counter reset is 1, the count and the prescaler stay at 0. While run is 0, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| count_o | output | CNT_W | Current counter value |
| run_o | output | 1 | Counter run bit |
| flags_o | output | 7 | Sticky match flags |
| irq_o | output | 1 | Interrupt request (OR of flags) |
| pwm_o | output | 6 | PWM outputs, bit n-1 is output n |

## Verification
The hardest situation to reach from the ports is a shadow value that is written but not armed. It must survive several match-triggered resets without taking effect, and then move across on the first wrap after its latch bit is armed. The stimulus starts with all active values at zero, so the first step itself is a match reset that loads the armed set. It then changes one shadow mid-run and checks whole periods for the old duty. After that it arms the latch and checks whole periods for the new duty. A scoreboard compares every count position of a period against the edge rules, in both single-edge and dual-edge mode.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int NUM_MATCH = 7;
    localparam int NUM_OUT   = NUM_MATCH - 1;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_PRESC  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_MCTL   = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_OCTL   = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_LATCH  = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_MBASE  = 4'd8;

    localparam int OCTL_DUAL_LSB = 8;

    typedef struct packed {
        logic stop;
        logic rst;
        logic irq;
    } match_ctl_t;

    typedef enum logic {
        EDGE_SINGLE = 1'b0,
        EDGE_DUAL   = 1'b1
    } edge_mode_t;

    function automatic logic [NUM_MATCH-1:0] irq_mask(input match_ctl_t [NUM_MATCH-1:0] c);
        logic [NUM_MATCH-1:0] m;
        for (int i = 0; i < NUM_MATCH; i++) m[i] = c[i].irq;
        return m;
    endfunction

    function automatic logic [NUM_MATCH-1:0] rst_mask(input match_ctl_t [NUM_MATCH-1:0] c);
        logic [NUM_MATCH-1:0] m;
        for (int i = 0; i < NUM_MATCH; i++) m[i] = c[i].rst;
        return m;
    endfunction

    function automatic logic [NUM_MATCH-1:0] stop_mask(input match_ctl_t [NUM_MATCH-1:0] c);
        logic [NUM_MATCH-1:0] m;
        for (int i = 0; i < NUM_MATCH; i++) m[i] = c[i].stop;
        return m;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] pr,
    output logic             tick
);
    logic [PRE_W-1:0] pc_q;

    assign tick = run && !clr && (pc_q >= pr);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= (pc_q >= pr) ? '0 : pc_q + PRE_W'(1);
        end
    end

    // R2: with a non-zero divisor, two steps are never adjacent
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && pr != '0) |=> (!tick || pr == '0));

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_MATCH-1:0] wr_match,
    input  logic [CNT_W-1:0]     wr_val,
    input  logic [NUM_MATCH-1:0] latch_set,
    input  logic                 tick,
    input  logic [CNT_W-1:0]     tc,
    input  logic                 reset_evt,
    output logic [NUM_MATCH-1:0] hit
);
    logic [NUM_MATCH-1:0][CNT_W-1:0] shadow_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] act_q;
    logic [NUM_MATCH-1:0]            latch_q;
    logic [NUM_MATCH-1:0]            xfer;

    assign xfer = reset_evt ? latch_q : '0;

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        assign hit[m] = tick && (tc == act_q[m]);

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[m] <= '0;
                act_q[m]    <= '0;
            end else begin
                if (wr_match[m]) shadow_q[m] <= wr_val;
                if (xfer[m])     act_q[m]    <= shadow_q[m];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= (latch_q & ~xfer) | latch_set;
    end

    // R4: active compare values move only on a match-triggered reset
    p_active_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !reset_evt |=> $stable(act_q));

    // R4: armed bits persist until a transfer or a new arm write
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!reset_evt && latch_set == '0) |=> $stable(latch_q));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic [NUM_MATCH-1:0] hit,
    input  logic [NUM_OUT-1:1]   dual,
    input  logic [NUM_OUT-1:0]   oen,
    input  logic                 pwm_en,
    output logic [NUM_OUT-1:0]   pwm_o
);
    logic [NUM_OUT-1:0] st_q;
    logic [NUM_OUT-1:0] set_c;
    logic [NUM_OUT-1:0] clr_c;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        if (i == 0) begin : g_first
            assign set_c[i] = hit[0];
        end else begin : g_sel
            assign set_c[i] = (edge_mode_t'(dual[i]) == EDGE_DUAL) ? hit[i] : hit[0];
        end
        assign clr_c[i] = hit[i+1];

        always_ff @(posedge clk) begin
            if (rst || clr)     st_q[i] <= 1'b0;
            else if (clr_c[i])  st_q[i] <= 1'b0;
            else if (set_c[i])  st_q[i] <= 1'b1;
        end

        assign pwm_o[i] = st_q[i] && oen[i] && pwm_en;

        // R5 R6: a falling-edge match always leaves the output low
        p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
            clr_c[i] |=> !st_q[i]);
    end

endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [CNT_W-1:0]     count_o,
    output logic                 run_o,
    output logic [NUM_MATCH-1:0] flags_o,
    output logic                 irq_o,
    output logic [NUM_OUT-1:0]   pwm_o
);
    localparam int MCTL_W = 3 * NUM_MATCH;

    logic                            run_q, creset_q, pwm_en_q;
    logic [PRE_W-1:0]                pr_q;
    match_ctl_t [NUM_MATCH-1:0]      mctl_q;
    logic [NUM_OUT-1:0]              oen_q;
    logic [NUM_OUT-1:1]              dual_q;
    logic [NUM_MATCH-1:0]            flags_q;
    logic [CNT_W-1:0]                tc_q;

    logic                            wr_ctrl, wr_presc, wr_mctl, wr_octl, wr_latch, wr_flags;
    logic [NUM_MATCH-1:0]            wr_match;
    logic [NUM_MATCH-1:0]            hit, latch_set, flag_clr;
    logic                            tick, reset_evt, stop_evt;
    logic                            unused_wdata;

    assign unused_wdata = ^wr_data;

    assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
    assign wr_presc = wr_en && (wr_addr == ADR_PRESC);
    assign wr_mctl  = wr_en && (wr_addr == ADR_MCTL);
    assign wr_octl  = wr_en && (wr_addr == ADR_OCTL);
    assign wr_latch = wr_en && (wr_addr == ADR_LATCH);
    assign wr_flags = wr_en && (wr_addr == ADR_FLAGS);

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_dec
        assign wr_match[m] = wr_en && (wr_addr == ADR_MBASE + ADDR_W'(m));
    end

    assign latch_set = wr_latch ? wr_data[NUM_MATCH-1:0] : '0;
    assign flag_clr  = wr_flags ? wr_data[NUM_MATCH-1:0] : '0;

    assign reset_evt = |(hit & rst_mask(mctl_q));
    assign stop_evt  = |(hit & stop_mask(mctl_q));

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .clr  (creset_q),
        .pr   (pr_q),
        .tick (tick)
    );

    pwm_match_bank #(.CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_match  (wr_match),
        .wr_val    (wr_data[CNT_W-1:0]),
        .latch_set (latch_set),
        .tick      (tick),
        .tc        (tc_q),
        .reset_evt (reset_evt),
        .hit       (hit)
    );

    pwm_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .clr    (creset_q),
        .hit    (hit),
        .dual   (dual_q),
        .oen    (oen_q),
        .pwm_en (pwm_en_q),
        .pwm_o  (pwm_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            creset_q <= 1'b0;
            pwm_en_q <= 1'b0;
            pr_q     <= '0;
            mctl_q   <= '0;
            oen_q    <= '0;
            dual_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q    <= wr_data[0];
                creset_q <= wr_data[1];
                pwm_en_q <= wr_data[2];
            end
            if (stop_evt) run_q <= 1'b0;
            if (wr_presc) pr_q <= wr_data[PRE_W-1:0];
            if (wr_mctl)  mctl_q <= wr_data[MCTL_W-1:0];
            if (wr_octl) begin
                oen_q  <= wr_data[NUM_OUT-1:0];
                dual_q <= wr_data[OCTL_DUAL_LSB+NUM_OUT-1:OCTL_DUAL_LSB+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            tc_q <= '0;
        else if (creset_q)  tc_q <= '0;
        else if (tick) begin
            if (reset_evt)      tc_q <= '0;
            else if (!stop_evt) tc_q <= tc_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | (hit & irq_mask(mctl_q));
    end

    assign count_o = tc_q;
    assign run_o   = run_q;
    assign flags_o = flags_q;
    assign irq_o   = |flags_q;

    // R10: a stopped counter holds its value
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !creset_q) |=> $stable(tc_q));

    // R10: counter reset forces zero
    p_creset_zero_r10: assert property (@(posedge clk) disable iff (rst)
        creset_q |=> (tc_q == '0));

    // R9: a stop match drops the run bit
    p_stop_clears_run_r9: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !run_q);

    // R8: flags only fall through a clear write
    p_flags_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: tb/tb_pwm_match_timer.sv
module tb_pwm_match_timer;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [CNT_W-1:0] count_o;
    logic        run_o;
    logic [6:0]  flags_o;
    logic        irq_o;
    logic [5:0]  pwm_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwm_match_timer #(.CNT_W(CNT_W), .PRE_W(8)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .run_o(run_o), .flags_o(flags_o), .irq_o(irq_o), .pwm_o(pwm_o)
    );

    typedef struct {
        int         tc;
        logic [5:0] pwm;
        int         req;
    } sb_item_t;

    sb_item_t sb_q[$];
    bit mon_busy = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected outputs from the edge rules: out1 single (MR0 period, MR1),
    // out2 single (MR2), out3 dual (MR2 rise, MR3 fall)
    function automatic logic [5:0] exp_pwm(input int tc, input int mr1, input logic [2:0] oen);
        logic [5:0] e = '0;
        e[0] = oen[0] && (tc <= mr1);
        e[1] = oen[1] && (tc <= 2);
        e[2] = oen[2] && (tc > 2) && (tc <= 6);
        return e;
    endfunction

    task automatic push_period(input int mr1, input logic [2:0] oen, input int req);
        for (int t = 0; t < 10; t++) begin
            sb_item_t it;
            it.tc = t; it.pwm = exp_pwm(t, mr1, oen); it.req = req;
            sb_q.push_back(it);
        end
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // monitor: pops expected items and compares when the count reaches them
    initial begin
        forever begin
            sb_item_t it;
            bit found;
            wait (sb_q.size() > 0);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            found = 1'b0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (int'(count_o) == it.tc) begin
                    found = 1'b1;
                    break;
                end
            end
            if (!found) chk(1'b0, $sformatf("R%0d count reach", it.req), int'(count_o), it.tc);
            else        chk(pwm_o == it.pwm, $sformatf("R%0d pwm at count %0d", it.req, it.tc),
                            int'(pwm_o), int'(it.pwm));
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [CNT_W-1:0] prev;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(count_o == 0, "R1 count", int'(count_o), 0);
        chk(pwm_o == 0,   "R1 pwm", int'(pwm_o), 0);
        chk(flags_o == 0 && !irq_o, "R1 flags", int'(flags_o), 0);
        chk(!run_o, "R1 run", int'(run_o), 0);

        // R2 prescale: divisor 4
        wr(4'd1, 32'd3);
        wr(4'd0, 32'h1);
        prev = count_o;
        while (count_o == prev) @(negedge clk);
        prev = count_o; n = 0;
        while (count_o == prev) begin @(negedge clk); n++; end
        chk(n == 4, "R2 step spacing", n, 4);

        // R10 counter reset held, even with run set
        wr(4'd0, 32'h3);
        idle(3);
        chk(count_o == 0, "R10 reset hold", int'(count_o), 0);
        idle(3);
        chk(count_o == 0, "R10 reset hold later", int'(count_o), 0);
        wr(4'd0, 32'h0);
        idle(2);
        chk(count_o == 0, "R10 idle hold", int'(count_o), 0);

        // configure period 10, edges, interrupt on match 1
        wr(4'd1, 32'd0);
        wr(4'd8, 32'd9);
        wr(4'd9, 32'd4);
        wr(4'd10, 32'd2);
        wr(4'd11, 32'd6);
        wr(4'd2, 32'h0000_000A);   // R3: match0 reset bit1, match1 irq bit3
        wr(4'd4, 32'h0F);          // R4 arm 0..3
        wr(4'd3, 32'h0000_0407);   // R7 enables 1..3, R6 dual for output 3 (bit10)
        wr(4'd0, 32'h5);
        idle(25);
        // R3 period length
        while (count_o != 0) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (count_o != 0);
        chk(n == 10, "R3 period", n, 10);
        push_period(4, 3'b111, 5);  // R5 R6 single and dual edges

        // R8 flags: stop then W1C
        wr(4'd0, 32'h4);
        chk(flags_o[1] && irq_o, "R8 flag set", int'(flags_o), 2);
        wr(4'd5, 32'h0);
        chk(flags_o == 7'h02, "R8 write zero keeps", int'(flags_o), 2);
        wr(4'd5, 32'h02);
        chk(flags_o == 0 && !irq_o, "R8 clear", int'(flags_o), 0);

        // R4 unarmed shadow stays inactive across wraps
        wr(4'd9, 32'd7);
        wr(4'd0, 32'h5);
        idle(25);
        push_period(4, 3'b111, 4);
        wr(4'd4, 32'h02);
        idle(25);
        push_period(7, 3'b111, 4);

        // R7 output gating
        wr(4'd3, 32'h0000_0406);
        idle(12);
        push_period(7, 3'b110, 7);
        wr(4'd0, 32'h1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(pwm_o == 0, "R7 pwm disabled", int'(pwm_o), 0);
        end

        // R9 stop on match 1 (value 7)
        wr(4'd2, 32'h0000_002A);
        idle(30);
        chk(count_o == 7, "R9 held count", int'(count_o), 7);
        chk(!run_o, "R9 run cleared", int'(run_o), 0);
        idle(5);
        chk(count_o == 7, "R9 still held", int'(count_o), 7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule